// File: doc/BRIEF.md
# Dual-Role SPI Engine with Single-Wire Data Mode

This block is an 8-bit serial peripheral engine that acts either as the clock-generating master or as a slave clocked from outside. In the usual configuration data travels on two pins: one carries data from master to slave and the other carries data back. A pin-mode control bit folds both directions onto one wire. The role decides which wire is shared. A master keeps the master-out pin and a slave keeps the slave-out pin, and the unused wire stays undriven. A second control bit chooses whether the block drives the shared wire or only listens to it.

Software writes a byte to start a master transfer. The clock is idle-low and data goes out most significant bit first. Each received bit is sampled on the rising clock edge and the shift happens on the falling edge. The master clock rate comes from a programmable prescaler and a power-of-two rate select. When a byte has been received, a receive-full flag rises. That flag drives either an interrupt or a DMA request, never both. A read of the data or a DMA acknowledge clears it. An optional stop-in-wait setting freezes the engine while a wait-mode input is high.

Top module: `spi_bidir_engine`

## Requirements
- R1: After reset, all three pin output enables, rxFull, irq and dmaReq are 0, and baudRdata reads 0.
- R2: A baudWr pulse stores baudWdata[6:4] as prescaler P and baudWdata[3:0] as rate select S, whether or not a transfer is running. baudRdata returns {0, P, S}, so bit 7 always reads 0.
- R3: In master mode, a txWr while idle starts a transfer. sckOut is low while idle. Each sckOut half period lasts H = (P+1)·2^min(S,8) clock cycles, so the first rising edge comes H cycles after the write, and there are 8 clock periods in total.
- R4: The master presents the written byte MSB first on its data output pin. Each bit changes on a falling sckOut edge. The input bit is sampled on each rising edge. In the cycle of the eighth falling edge, busy drops, rxFull rises and rxData holds the received byte, MSB first.
- R5: Master in two-pin mode (bidirMode=0): mosiOe=1, data comes in on misoIn, and misoOe=0. bidirOe has no effect.
- R6: Master in single-wire mode (bidirMode=1): the shared pin is MOSI. mosiOe equals bidirOe, input data is taken from mosiIn, and misoOe=0. With bidirOe=0 the master still generates sckOut and receives.
- R7: Slave, with ssN low: in two-pin mode it drives misoOut with misoOe=1 and takes input from mosiIn. In single-wire mode the shared pin is MISO, misoOe equals bidirOe, and input comes from misoIn. In both modes mosiOe=0. With ssN high, misoOe=0.
- R8: A slave loads txData while ssN is high and shifts on sckIn: it samples on the rising edge and shifts out on the falling edge. rxFull rises within 4 cycles after the eighth falling edge, and rxData holds the received byte.
- R9: With rxDmaEn=0, irq follows rxFull and dmaReq=0. With rxDmaEn=1 and spiEn=1, dmaReq follows rxFull and irq=0.
- R10: A one-cycle rxRd or dmaAck pulse clears rxFull.
- R11: With stopInWait=1, each cycle in which waitMode is high holds the master sckOut and the bit timing for one cycle. With stopInWait=0, waitMode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiEn | input | 1 | System enable; clears the engine when low |
| masterSel | input | 1 | 1 selects master, 0 selects slave |
| bidirMode | input | 1 | 1 selects single-wire data mode |
| bidirOe | input | 1 | Drive enable for the shared wire in single-wire mode |
| rxDmaEn | input | 1 | Routes receive-full to the DMA request instead of the interrupt |
| stopInWait | input | 1 | Freeze the engine while waitMode is high |
| waitMode | input | 1 | Wait-mode indication |
| baudWr | input | 1 | Write strobe for the baud register |
| baudWdata | input | 8 | Baud write data: [6:4] prescaler, [3:0] rate select |
| baudRdata | output | 8 | Baud register readback, bit 7 reads 0 |
| txWr | input | 1 | Transmit data write strobe |
| txData | input | 8 | Transmit byte |
| rxRd | input | 1 | Receive data read strobe, clears rxFull |
| rxData | output | 8 | Last received byte |
| rxFull | output | 1 | Receive-full flag |
| busy | output | 1 | Master transfer in progress |
| irq | output | 1 | Receive interrupt |
| dmaReq | output | 1 | Receive DMA request |
| dmaAck | input | 1 | DMA acknowledge, clears rxFull |
| ssN | input | 1 | Active-low slave select |
| sckIn | input | 1 | Serial clock input (slave) |
| sckOut | output | 1 | Serial clock output (master) |
| sckOe | output | 1 | Serial clock output enable |
| mosiIn | input | 1 | Master-out pin, input side |
| mosiOut | output | 1 | Master-out pin, output side |
| mosiOe | output | 1 | Master-out pin output enable |
| misoIn | input | 1 | Slave-out pin, input side |
| misoOut | output | 1 | Slave-out pin, output side |
| misoOe | output | 1 | Slave-out pin output enable |

## Verification
A wrong baud count or a stuck phase flop shows up on sckOut within one half period of the write. The bench follows the clock level in every cycle of a master transfer, so such a fault is reported in the first wrong cycle. A bad shift or sample path shows on the data output pin at the next falling edge, and in rxData once the byte completes. Routing faults show as a wrong output enable in the first cycle after the configuration is applied. Steering faults show on irq or dmaReq as soon as rxFull rises.

// File: rtl/spi_bidir_pkg.sv
package spi_bidir_pkg;
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic done;
  } strobe_t;
endpackage

// File: rtl/spi_bidir_ctrl.sv
module spi_bidir_ctrl
  import spi_bidir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    master,
  input  logic                    stopInWait,
  input  logic                    waitMode,
  input  logic                    baudWr,
  input  logic [PRE_W+RATE_W:0]   baudWdata,
  output logic [PRE_W+RATE_W:0]   baudRdata,
  input  logic                    txWr,
  input  logic                    sckIn,
  input  logic                    ssN,
  output logic                    sckOut,
  output logic                    busy,
  output strobe_t                 strb
);
  localparam int CNT_W = PRE_W + RATE_MAX + 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic [PRE_W-1:0]  preSel;
  logic [RATE_W-1:0] rateSel;
  logic [RATE_W-1:0] rateEff;
  logic [CNT_W-1:0]  halfLen;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              phase;
  logic [2:0]        sckSync;
  logic              run, tick, lastCnt, lastBit, sckRise, sckFall, slvActive;

  // baud register, writable at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSel  <= '0;
      rateSel <= '0;
    end else if (baudWr) begin
      preSel  <= baudWdata[PRE_W+RATE_W-1:RATE_W];
      rateSel <= baudWdata[RATE_W-1:0];
    end
  end
  assign baudRdata = {1'b0, preSel, rateSel};

  assign rateEff = (rateSel > RATE_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : rateSel;
  assign halfLen = (CNT_W'(preSel) + CNT_W'(1)) << rateEff;
  assign lastCnt = (cnt >= halfLen - CNT_W'(1));
  assign lastBit = (bitCnt == BIT_W'(DATA_W - 1));

  assign run  = enable & ~(stopInWait & waitMode);
  assign tick = run & master & busy & lastCnt;

  // slave clock synchroniser and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckSync <= '0;
    else       sckSync <= {sckSync[1:0], sckIn};
  end
  assign sckRise   = sckSync[1] & ~sckSync[2];
  assign sckFall   = ~sckSync[1] & sckSync[2];
  assign slvActive = run & ~master & ~ssN;

  always_comb begin
    strb.load   = run & txWr & (master ? ~busy : (ssN | (bitCnt == '0)));
    strb.sample = master ? (tick & ~phase) : (slvActive & sckRise);
    strb.shift  = master ? (tick & phase)  : (slvActive & sckFall);
    strb.done   = strb.shift & lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      bitCnt <= '0;
    end else if (!enable) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      bitCnt <= '0;
    end else if (run) begin
      if (master) begin
        if (strb.load) begin
          busy   <= 1'b1;
          phase  <= 1'b0;
          cnt    <= '0;
          bitCnt <= '0;
        end else if (busy) begin
          if (lastCnt) begin
            cnt   <= '0;
            phase <= ~phase;
            if (phase) begin
              bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
              if (lastBit) busy <= 1'b0;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end else begin
        busy  <= 1'b0;
        phase <= 1'b0;
        cnt   <= '0;
        if (ssN)              bitCnt <= '0;
        else if (strb.shift)  bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
      end
    end
  end

  assign sckOut = phase;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !sckOut); // R3
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && stopInWait && waitMode) |=> (!enable || ($stable(phase) && $stable(cnt)))); // R11
endmodule

// File: rtl/spi_bidir_dp.sv
module spi_bidir_dp
  import spi_bidir_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              master,
  input  logic              bidir,
  input  logic              bidirOe,
  input  logic              rxDmaEn,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRd,
  input  logic              dmaAck,
  input  logic              ssN,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              irq,
  output logic              dmaReq
);
  logic [DATA_W-1:0] shifter;
  logic              sampleBit;
  logic              dataIn;
  logic              txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter   <= '0;
      sampleBit <= 1'b0;
      rxData    <= '0;
      rxFull    <= 1'b0;
    end else begin
      if (strb.load)        shifter <= txData;
      else if (strb.shift)  shifter <= {shifter[DATA_W-2:0], sampleBit};
      if (strb.sample) sampleBit <= dataIn;
      if (strb.done) begin
        rxData <= {shifter[DATA_W-2:0], sampleBit};
        rxFull <= 1'b1;
      end else if (rxRd || dmaAck) begin
        rxFull <= 1'b0;
      end
    end
  end

  assign txBit = shifter[DATA_W-1];

  // pin routing by role and pin mode
  always_comb begin
    mosiOut = 1'b0;
    mosiOe  = 1'b0;
    misoOut = 1'b0;
    misoOe  = 1'b0;
    dataIn  = 1'b0;
    if (enable) begin
      if (master) begin
        mosiOut = txBit;
        mosiOe  = bidir ? bidirOe : 1'b1;
        dataIn  = bidir ? mosiIn : misoIn;
      end else begin
        misoOut = txBit;
        misoOe  = ~ssN & (bidir ? bidirOe : 1'b1);
        dataIn  = bidir ? misoIn : mosiIn;
      end
    end
  end

  assign irq    = rxFull & ~rxDmaEn;
  assign dmaReq = rxFull & rxDmaEn & enable;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN) !(mosiOe && misoOe)); // R6
  AST_RXFULL_ON_DONE: assert property (@(posedge clk) disable iff (!rstN) strb.done |=> rxFull); // R4
  AST_STEER_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(irq && dmaReq)); // R9
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && (rxRd || dmaAck) && !strb.done) |=> !rxFull); // R10
endmodule

// File: rtl/spi_bidir_engine.sv
module spi_bidir_engine
  import spi_bidir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spiEn,
  input  logic                  masterSel,
  input  logic                  bidirMode,
  input  logic                  bidirOe,
  input  logic                  rxDmaEn,
  input  logic                  stopInWait,
  input  logic                  waitMode,
  input  logic                  baudWr,
  input  logic [PRE_W+RATE_W:0] baudWdata,
  output logic [PRE_W+RATE_W:0] baudRdata,
  input  logic                  txWr,
  input  logic [DATA_W-1:0]     txData,
  input  logic                  rxRd,
  output logic [DATA_W-1:0]     rxData,
  output logic                  rxFull,
  output logic                  busy,
  output logic                  irq,
  output logic                  dmaReq,
  input  logic                  dmaAck,
  input  logic                  ssN,
  input  logic                  sckIn,
  output logic                  sckOut,
  output logic                  sckOe,
  input  logic                  mosiIn,
  output logic                  mosiOut,
  output logic                  mosiOe,
  input  logic                  misoIn,
  output logic                  misoOut,
  output logic                  misoOe
);
  strobe_t strb;

  spi_bidir_ctrl #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .RATE_W(RATE_W), .RATE_MAX(RATE_MAX)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(spiEn), .master(masterSel),
    .stopInWait(stopInWait), .waitMode(waitMode),
    .baudWr(baudWr), .baudWdata(baudWdata), .baudRdata(baudRdata),
    .txWr(txWr), .sckIn(sckIn), .ssN(ssN),
    .sckOut(sckOut), .busy(busy), .strb(strb)
  );

  spi_bidir_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .enable(spiEn), .master(masterSel),
    .bidir(bidirMode), .bidirOe(bidirOe), .rxDmaEn(rxDmaEn), .strb(strb),
    .txData(txData), .rxRd(rxRd), .dmaAck(dmaAck), .ssN(ssN),
    .mosiIn(mosiIn), .misoIn(misoIn),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoOut(misoOut), .misoOe(misoOe),
    .rxData(rxData), .rxFull(rxFull), .irq(irq), .dmaReq(dmaReq)
  );

  assign sckOe = spiEn & masterSel;
endmodule

// File: tb/spi_bidir_engine_tb_top.sv
module spi_bidir_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiEn = 0, masterSel = 0, bidirMode = 0, bidirOe = 0, rxDmaEn = 0;
  logic stopInWait = 0, waitMode = 0, baudWr = 0, txWr = 0, rxRd = 0, dmaAck = 0;
  logic ssN = 1, sckIn = 0, mosiIn = 0, misoIn = 0;
  logic [7:0] baudWdata = 0, txData = 0;
  logic [7:0] baudRdata, rxData;
  logic rxFull, busy, irq, dmaReq, sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;

  int checks = 0;
  int errors = 0;

  spi_bidir_engine dut_i (
    .clk(clk), .rstN(rstN), .spiEn(spiEn), .masterSel(masterSel),
    .bidirMode(bidirMode), .bidirOe(bidirOe), .rxDmaEn(rxDmaEn),
    .stopInWait(stopInWait), .waitMode(waitMode),
    .baudWr(baudWr), .baudWdata(baudWdata), .baudRdata(baudRdata),
    .txWr(txWr), .txData(txData), .rxRd(rxRd), .rxData(rxData),
    .rxFull(rxFull), .busy(busy), .irq(irq), .dmaReq(dmaReq), .dmaAck(dmaAck),
    .ssN(ssN), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_baud(input logic [7:0] v);
    @(negedge clk); baudWdata = v; baudWr = 1;
    @(negedge clk); baudWr = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rxRd = 1;
    @(negedge clk); rxRd = 0;
  endtask

  // behavioural model of one master byte: clock level and data bit from elapsed cycles
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] pat, input int half,
                             input int stopAt, input int stopLen, input string req);
    int k = 0;
    int w = 0;
    int j;
    bit expOe;
    @(negedge clk); txData = tx; txWr = 1;
    @(negedge clk); txWr = 0;
    expOe = bidirMode ? bidirOe : 1'b1;
    while (k < 16*half) begin
      j = k / (2*half);
      if (bidirMode) begin mosiIn = pat[7-j]; misoIn = ~pat[7-j]; end
      else           begin misoIn = pat[7-j]; mosiIn = ~pat[7-j]; end
      chk(sckOut == (((k/half) % 2) == 1), {req, " sck"}, int'(sckOut), (k/half) % 2);
      chk(mosiOe == expOe && misoOe == 1'b0 && sckOe == 1'b1, {req, " oe"},
          int'({sckOe, mosiOe, misoOe}), int'({1'b1, expOe, 1'b0}));
      if (expOe) chk(mosiOut == tx[7-j], {req, " R4 data out"}, int'(mosiOut), int'(tx[7-j]));
      chk(busy == 1'b1, {req, " busy"}, int'(busy), 1);
      if (stopAt >= 0 && k >= stopAt && w < stopLen) begin
        waitMode = 1; w++;
        if (!stopInWait) k++;
      end else begin
        waitMode = 0; k++;
      end
      @(negedge clk);
    end
    waitMode = 0;
    chk(sckOut == 0 && busy == 0, {req, " R4 end idle"}, int'({sckOut, busy}), 0);
    chk(rxFull == 1, {req, " R4 rxFull"}, int'(rxFull), 1);
    chk(rxData == pat, {req, " R4 rxData"}, int'(rxData), int'(pat));
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] pat, input string req);
    bit expOe;
    masterSel = 0; ssN = 1;
    @(negedge clk); txData = tx; txWr = 1;
    @(negedge clk); txWr = 0; ssN = 0;
    repeat (4) @(negedge clk);
    expOe = bidirMode ? bidirOe : 1'b1;
    for (int j = 0; j < 8; j++) begin
      if (bidirMode) begin misoIn = pat[7-j]; mosiIn = ~pat[7-j]; end
      else           begin mosiIn = pat[7-j]; misoIn = ~pat[7-j]; end
      chk(misoOut == tx[7-j], {req, " R8 slave out"}, int'(misoOut), int'(tx[7-j]));
      chk(misoOe == expOe && mosiOe == 0 && sckOe == 0, {req, " R7 oe"},
          int'({sckOe, mosiOe, misoOe}), int'({2'b00, expOe}));
      sckIn = 1; repeat (8) @(negedge clk);
      sckIn = 0; repeat (8) @(negedge clk);
    end
    chk(rxFull == 1, {req, " R8 rxFull"}, int'(rxFull), 1);
    chk(rxData == pat, {req, " R8 rxData"}, int'(rxData), int'(pat));
    ssN = 1;
    @(negedge clk);
    chk(misoOe == 0, {req, " R7 deselect oe"}, int'(misoOe), 0);
    pulse_rd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sckOe == 0 && mosiOe == 0 && misoOe == 0, "R1 oe", int'({sckOe, mosiOe, misoOe}), 0);
    chk(rxFull == 0 && irq == 0 && dmaReq == 0, "R1 flags", int'({rxFull, irq, dmaReq}), 0);
    chk(baudRdata == 8'h00, "R1 baud", int'(baudRdata), 0);
    rstN = 1;
    @(negedge clk);

    // R2 readback
    write_baud(8'hFF);
    chk(baudRdata == 8'h7F, "R2 bit7 reads 0", int'(baudRdata), 8'h7F);
    write_baud(8'h00);
    chk(baudRdata == 8'h00, "R2 write zero", int'(baudRdata), 0);

    // R3 R4 R5: fastest rate, two-pin master, bidirOe ignored
    spiEn = 1; masterSel = 1; bidirMode = 0; bidirOe = 0;
    master_xfer(8'hA5, 8'h3C, 1, -1, 0, "R5 master two-pin H=1");
    chk(irq == 1 && dmaReq == 0, "R9 irq path", int'({irq, dmaReq}), 2);
    pulse_rd();
    chk(rxFull == 0 && irq == 0, "R10 read clears", int'({rxFull, irq}), 0);

    // R3 prescaler 2, rate 1: H=6
    write_baud(8'h21);
    chk(baudRdata == 8'h21, "R2 readback 21", int'(baudRdata), 8'h21);
    master_xfer(8'h5A, 8'hC3, 6, -1, 0, "R3 master H=6");
    pulse_rd();

    // R3 rate clamp: S=15 behaves as 8, H=256
    write_baud(8'h0F);
    master_xfer(8'h81, 8'h7E, 256, -1, 0, "R3 clamp H=256");
    pulse_rd();

    // R6 single-wire master driving and listening
    write_baud(8'h01);
    bidirMode = 1; bidirOe = 1;
    master_xfer(8'hF0, 8'h96, 2, -1, 0, "R6 bidir oe1");
    pulse_rd();
    bidirOe = 0;
    master_xfer(8'h0F, 8'h69, 2, -1, 0, "R6 bidir oe0");

    // R9 R10 DMA steering and acknowledge
    rxDmaEn = 1;
    @(negedge clk);
    chk(dmaReq == 1 && irq == 0, "R9 dma path", int'({irq, dmaReq}), 1);
    @(negedge clk); dmaAck = 1;
    @(negedge clk); dmaAck = 0;
    chk(rxFull == 0 && dmaReq == 0, "R10 ack clears", int'({rxFull, dmaReq}), 0);
    rxDmaEn = 0;

    // R11 wait stop freezes, no stop keeps running
    bidirMode = 0;
    stopInWait = 1;
    master_xfer(8'hC6, 8'h5B, 2, 5, 7, "R11 stop in wait");
    pulse_rd();
    stopInWait = 0;
    master_xfer(8'h39, 8'hE4, 2, 5, 7, "R11 wait no stop");
    pulse_rd();

    // R7 R8 slave modes
    slave_xfer(8'hB2, 8'h4D, "R7 slave two-pin");
    bidirMode = 1; bidirOe = 1;
    slave_xfer(8'h1E, 8'hD8, "R7 slave bidir oe1");
    bidirOe = 0;
    slave_xfer(8'h77, 8'h2A, "R7 slave bidir oe0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule